// File: doc/BRIEF.md
# Frame Sequencer Interrupt Flag

This block is the divider that paces a sound unit's frame sequencer, running on the processor clock, together with the interrupt flag that the sequencer raises at the end of its four-step period. Software writes a one-byte mode register to restart the sequence. Bit 7 of that byte picks the long five-step period, which never interrupts. Bit 6 inhibits the interrupt. Software reads a status byte in which bit 6 mirrors the flag, and that read clears the flag. A level interrupt output requests service from the CPU while the flag is set and the inhibit bit is clear.

The timing is exact to the cycle. The flag is driven high on three cycles in a row at the end of the period. A status read that lands on one of the first two of those cycles therefore does not leave the flag clear. A free-running even/odd toggle decides whether a mode write restarts the count at once or one clock later. There are no data streams here: every pin is a plain strobe or level, with no valid/ready handshake and no back-pressure. Status data is combinational from the flag register and is meaningful in the cycle where `status_rd` is high.

Top module: `fsq_frame_irq`

## Requirements
- R1: After reset, `status_data` reads 0x00 and `cpu_irq` is low.
- R2: The status byte carries the flag in bit 6 (value 0x40). All other bits are always zero.
- R3: A mode write of 0x00 in an even cycle (cycle 0) selects four-step mode. A status read in cycle FLAG_AT-1 (29830) returns 0x00, and a read in cycle FLAG_AT (29831) or later returns 0x40.
- R4: A status read clears the flag, except while the flag is still being driven. A read in cycle 29831 or 29832 leaves a read four cycles later at 0x40. A read in cycle 29833 or later leaves such a read at 0x00.
- R5: `cpu_irq` is high exactly when the flag is set and the inhibit bit (write bit 6) is clear. After an even 0x00 write it is low in cycle 29830 and high in cycle 29831.
- R6: A mode write with bit 6 set clears the flag and keeps it clear for as long as the inhibit bit stays set, even through the end of the four-step period.
- R7: A toggle marks cycles as even or odd, and the first cycle after reset is even. A mode write in an odd cycle shifts every timing point of R3, R4 and R5 one cycle later.
- R8: A mode write with bit 7 set selects five-step mode, in which the flag never sets and the count wraps after LONG_LEN (37282) cycles.
- R9: In four-step mode the count wraps after cycle FLAG_AT+SPAN-1 (29833), so the flag sets again FLAG_AT+SPAN (29834) cycles after the first time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_wr | input | 1 | Mode register write strobe, one cycle per write |
| mode_data | input | 8 | Write byte: bit 7 five-step mode, bit 6 interrupt inhibit |
| status_rd | input | 1 | Status read strobe; clears the flag at the end of the cycle |
| status_data | output | 8 | Status byte, flag in bit 6 |
| cpu_irq | output | 1 | Level interrupt request to the CPU |

## Verification
The bench uses a short period so that it can sweep the first status read through every cycle around the flag window, for both write parities. For each read, the bench does a second read four cycles later. This pair tells apart "not yet set", "set and the clear did not stick" and "set and cleared". The odd-parity half of the sweep confirms the one-cycle shift. Separate patterns check the following: the interrupt edge, an inhibit write after the flag is up, an inhibited four-step period, the period wrap with its repeated window, and five-step periods at both parities, where the flag must stay clear.

// File: rtl/fsq_pkg.sv
package fsq_pkg;
  localparam int MODE_SEL_BIT = 7;
  localparam int INHIBIT_BIT  = 6;
  localparam int FLAG_BIT     = 6;

  typedef enum logic {
    SEQ_FOUR = 1'b0,
    SEQ_FIVE = 1'b1
  } seq_mode_e;
endpackage

// File: rtl/fsq_parity.sv
module fsq_parity (
  input  logic clk,
  input  logic rst_n,
  output logic odd_q
);
  // Free-running even/odd marker; the first cycle after reset is even.
  always_ff @(posedge clk) begin
    if (!rst_n) odd_q <= 1'b0;
    else        odd_q <= ~odd_q;
  end
endmodule

// File: rtl/fsq_counter.sv
module fsq_counter #(
  parameter int W        = 16,
  parameter int P4_LEN   = 29834,
  parameter int P5_LEN   = 37282,
  parameter int FLAG_AT  = 29831,
  parameter int SPAN     = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         restart,
  input  logic         odd_slot,
  input  logic         five_mode,
  output logic [W-1:0] cnt_q,
  output logic         set_now
);
  localparam logic [W-1:0] LAST4  = W'(P4_LEN - 1);
  localparam logic [W-1:0] LAST5  = W'(P5_LEN - 1);
  localparam logic [W-1:0] SET_LO = W'(FLAG_AT - 1);
  localparam logic [W-1:0] SET_HI = W'(FLAG_AT + SPAN - 2);

  logic [W-1:0] last_cnt;
  assign last_cnt = five_mode ? LAST5 : LAST4;

  // An even-cycle restart is already one count in at the next cycle;
  // an odd-cycle restart loses one clock.
  always_ff @(posedge clk) begin
    if (!rst_n)                 cnt_q <= '0;
    else if (restart)           cnt_q <= odd_slot ? '0 : W'(1);
    else if (cnt_q >= last_cnt) cnt_q <= '0;
    else                        cnt_q <= cnt_q + W'(1);
  end

  // Drive window: the flag is (re)set on SPAN consecutive edges.
  assign set_now = !five_mode && (cnt_q >= SET_LO) && (cnt_q <= SET_HI);
endmodule

// File: rtl/fsq_flag.sv
module fsq_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic force_clr,
  input  logic set_now,
  input  logic rd_clr,
  output logic flag_q
);
  // Priority: inhibit clear, then set, then read clear.
  always_ff @(posedge clk) begin
    if (!rst_n)         flag_q <= 1'b0;
    else if (force_clr) flag_q <= 1'b0;
    else if (set_now)   flag_q <= 1'b1;
    else if (rd_clr)    flag_q <= 1'b0;
  end
endmodule

// File: rtl/fsq_frame_irq.sv
module fsq_frame_irq #(
  parameter int FLAG_AT  = 29831,
  parameter int SPAN     = 3,
  parameter int LONG_LEN = 37282
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       mode_wr,
  input  logic [7:0] mode_data,
  input  logic       status_rd,
  output logic [7:0] status_data,
  output logic       cpu_irq
);
  import fsq_pkg::*;

  localparam int P4_LEN = FLAG_AT + SPAN;
  localparam int MAXLEN = (LONG_LEN > P4_LEN) ? LONG_LEN : P4_LEN;
  localparam int W      = $clog2(MAXLEN + 1);

  seq_mode_e    mode_q;
  logic         inh_q;
  logic         five_mode;
  logic         par_q;
  logic [W-1:0] cnt_q;
  logic         set_now;
  logic         flag_q;
  logic         wr_inh;
  logic         unused_mode_bits;

  assign unused_mode_bits = ^mode_data[5:0];
  assign wr_inh    = mode_wr && mode_data[INHIBIT_BIT];
  assign five_mode = (mode_q == SEQ_FIVE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= SEQ_FOUR;
      inh_q  <= 1'b0;
    end else if (mode_wr) begin
      mode_q <= mode_data[MODE_SEL_BIT] ? SEQ_FIVE : SEQ_FOUR;
      inh_q  <= mode_data[INHIBIT_BIT];
    end
  end

  fsq_parity u_par (
    .clk   (clk),
    .rst_n (rst_n),
    .odd_q (par_q)
  );

  fsq_counter #(
    .W       (W),
    .P4_LEN  (P4_LEN),
    .P5_LEN  (LONG_LEN),
    .FLAG_AT (FLAG_AT),
    .SPAN    (SPAN)
  ) u_cnt (
    .clk       (clk),
    .rst_n     (rst_n),
    .restart   (mode_wr),
    .odd_slot  (par_q),
    .five_mode (five_mode),
    .cnt_q     (cnt_q),
    .set_now   (set_now)
  );

  fsq_flag u_flag (
    .clk       (clk),
    .rst_n     (rst_n),
    .force_clr (inh_q || wr_inh),
    .set_now   (set_now),
    .rd_clr    (status_rd),
    .flag_q    (flag_q)
  );

  always_comb begin
    status_data           = '0;
    status_data[FLAG_BIT] = flag_q;
  end

  assign cpu_irq = flag_q && !inh_q;
endmodule

// File: rtl/fsq_frame_irq_chk.sv
module fsq_frame_irq_chk #(
  parameter int W       = 16,
  parameter int FLAG_AT = 29831,
  parameter int P4_LEN  = 29834
) (
  input logic         clk,
  input logic         rst_n,
  input logic         mode_wr,
  input logic [7:0]   mode_data,
  input logic         status_rd,
  input logic         par_q,
  input logic [W-1:0] cnt_q,
  input logic         set_now,
  input logic         flag_q,
  input logic         inh_q,
  input logic         five_mode,
  input logic         cpu_irq
);
  localparam logic [W-1:0] PRE_SET = W'(FLAG_AT - 1);
  localparam logic [W-1:0] LAST4   = W'(P4_LEN - 1);

  p_flag_sets_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!five_mode && !inh_q && !(mode_wr && mode_data[6]) && cnt_q == PRE_SET) |=> flag_q);

  p_read_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (status_rd && !set_now) |=> !flag_q);

  p_irq_masked_r5: assert property (@(posedge clk) disable iff (!rst_n)
    inh_q |-> !cpu_irq);

  p_inhibit_holds_r6: assert property (@(posedge clk) disable iff (!rst_n)
    inh_q |=> !flag_q);

  p_parity_toggle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (par_q != $past(par_q)));

  p_odd_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_wr && par_q) |=> (cnt_q == '0));

  p_even_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_wr && !par_q) |=> (cnt_q == W'(1)));

  p_five_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (five_mode && !flag_q) |=> !flag_q);

  p_wrap_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!five_mode && !mode_wr && cnt_q == LAST4) |=> (cnt_q == '0));
endmodule

bind fsq_frame_irq fsq_frame_irq_chk #(
  .W       (W),
  .FLAG_AT (FLAG_AT),
  .P4_LEN  (P4_LEN)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .mode_wr   (mode_wr),
  .mode_data (mode_data),
  .status_rd (status_rd),
  .par_q     (par_q),
  .cnt_q     (cnt_q),
  .set_now   (set_now),
  .flag_q    (flag_q),
  .inh_q     (inh_q),
  .five_mode (five_mode),
  .cpu_irq   (cpu_irq)
);

// File: tb/fsq_frame_irq_test.sv
`timescale 1ns/1ps
module fsq_frame_irq_test;
  localparam int FA   = 20;
  localparam int SP   = 3;
  localparam int LL   = 31;
  localparam int P4   = FA + SP;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       mode_wr = 1'b0;
  logic [7:0] mode_data = 8'h00;
  logic       status_rd = 1'b0;
  logic [7:0] status_data;
  logic       cpu_irq;

  int total = 0;
  int bad = 0;
  int pc = 0;

  always #2.5 clk = ~clk;
  always @(posedge clk) if (rst_n) pc <= pc + 1;

  fsq_frame_irq #(.FLAG_AT(FA), .SPAN(SP), .LONG_LEN(LL)) uut (
    .clk(clk), .rst_n(rst_n), .mode_wr(mode_wr), .mode_data(mode_data),
    .status_rd(status_rd), .status_data(status_data), .cpu_irq(cpu_irq)
  );

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic mode_write(logic [7:0] v);
    mode_wr = 1'b1; mode_data = v;
    @(negedge clk);
    mode_wr = 1'b0; mode_data = 8'h00;
  endtask

  task automatic status_read(output logic [7:0] v);
    status_rd = 1'b1;
    #1 v = status_data;
    @(negedge clk);
    status_rd = 1'b0;
  endtask

  task automatic align(int p);
    if ((pc % 2) != p) tick(1);
  endtask

  // Write 0x00 in a cycle of parity p (cycle 0); returns at cycle 1.
  task automatic start_four(int p);
    mode_write(8'h40);
    tick(1);
    align(p);
    mode_write(8'h00);
  endtask

  initial begin
    logic [7:0] a, b;
    int errs;
    tick(3);
    rst_n = 1'b1;
    #1;
    chk("R1 reset status", status_data, 8'h00);
    chk("R1 reset irq", {7'd0, cpu_irq}, 8'h00);

    // Sweep of read position, both parities (R2, R3, R4, R7)
    for (int p = 0; p < 2; p++) begin
      for (int r = FA - 4; r <= FA + SP + 2; r++) begin
        int f;
        logic e1, e2;
        f  = FA + p;
        e1 = (r >= f);
        e2 = (r + 4 >= f) && !(r >= f + SP - 1);
        start_four(p);
        tick(r - 1);
        status_read(a);
        tick(3);
        status_read(b);
        chk(p ? "R7 odd first read" : "R3 R2 first read", a, e1 ? 8'h40 : 8'h00);
        chk(p ? "R7 odd second read" : "R4 second read", b, e2 ? 8'h40 : 8'h00);
      end
    end

    // Interrupt edge and inhibit after set (R5, R6)
    start_four(0);
    tick(FA - 2);
    #1 chk("R5 irq before window", {7'd0, cpu_irq}, 8'h00);
    tick(1);
    #1 chk("R5 irq at window", {7'd0, cpu_irq}, 8'h01);
    tick(1);
    mode_write(8'h40);
    #1 chk("R6 irq after inhibit", {7'd0, cpu_irq}, 8'h00);
    status_read(a);
    chk("R6 flag cleared by inhibit", a, 8'h00);

    // Inhibited four-step period (R6)
    align(0);
    mode_write(8'h40);
    errs = 0;
    for (int t = 1; t < P4 + 2; t++) begin
      #1 if (cpu_irq !== 1'b0) errs++;
      tick(1);
    end
    status_read(a);
    chk("R6 inhibited period irq", 8'(errs), 8'h00);
    chk("R6 inhibited period status", a, 8'h00);

    // Wrap and repeated window (R9)
    start_four(0);
    tick(FA + SP - 1);
    status_read(a);
    chk("R9 read after window", a, 8'h40);
    tick(P4 + FA - 1 - (FA + SP + 1));
    status_read(a);
    chk("R9 before second window", a, 8'h00);
    status_read(a);
    chk("R9 second window", a, 8'h40);

    // Five-step at both parities (R8)
    for (int p = 0; p < 2; p++) begin
      mode_write(8'h40);
      tick(1);
      align(p);
      mode_write(8'h80);
      errs = 0;
      for (int t = 1; t < 3 * LL; t++) begin
        #1 if (cpu_irq !== 1'b0 || status_data !== 8'h00) errs++;
        tick(1);
      end
      chk("R8 five-step never sets", 8'(errs), 8'h00);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog actual=%h expected=%h", 8'h01, 8'h00);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule